// File: doc/BRIEF.md
# Nested Program/Erase Suspend Controller

This block sequences the program/erase engine of a dual-bank flash array. Decoded bus commands arrive one per cycle, each with a target bank and block. For every command that reaches it while the chip is selected, the block decides whether to accept or reject it. It tracks which operation owns the engine, and tells the engine when to run and when to hold. It also drives a read-path select that picks either array data or the status register.

Suspension can nest. An erase can be paused. A program can then be started in a different block, and that program can be paused too. A resume always undoes only the innermost pause. The paused erase cannot restart while the nested program is still outstanding. When chip select is high the controller keeps every suspension as it is and ignores the bus. A synchronous reset aborts whatever is in flight.

Top module: `susp_ctrl`

## Requirements
- R1: During and after reset `op_state` is 0, and `eng_run`, `eng_pause`, `read_status`, `cmd_accept` and `cmd_reject` are all 0. `op_state` encodes idle=0, erasing=1, erase-suspended=2, program-inside-erase-suspend=3, that program suspended=4, programming=5, program-suspended=6.
- R2: Command codes are read=0, read-status=1, read-signature=2, query=3, program=4, erase=5, suspend=6, resume=7, lock=8, lock-down=9, protection-program=10. From idle, program enters state 5 and erase enters state 1, both with `read_status`=1 and `eng_run`=1. Suspend and resume from idle are rejected.
- R3: A suspend addressed to the bank that owns the running operation moves to the matching suspended state, with `eng_pause`=1, `eng_run`=0 and `read_status`=1. A suspend addressed to any other bank is rejected.
- R4: While an operation runs, only three commands are accepted: read-status, suspend to the owning bank, and read to another bank (which leaves `read_status` as it is). Everything else is rejected.
- R5: `eng_done` completes a running operation. States 1 and 5 go to idle, and state 3 goes back to state 2. `eng_done` is ignored in idle and in suspended states. A command that arrives in the same cycle as a completion is rejected.
- R6: In any suspended state, read, read-signature and query are accepted and set `read_status`=0. Read-status is accepted and sets it to 1.
- R7: Only in the erase-suspended state are lock, lock-down, protection-program and program also accepted. A program to a block other than the suspended erase block enters state 3. A program to that block is rejected. In the program-suspended states these four commands are rejected.
- R8: A resume addressed to the owning bank steps back exactly one level: 2→1, 6→5, 4→3. It sets `read_status`=1. A resume addressed to any other bank is rejected.
- R9: The erase cannot resume while a program started in its suspension is outstanding. State 3 never moves directly to state 1.
- R10: While `ce_n`=1, commands produce neither accept nor reject, and the state and engine controls do not change.
- R11: Asserting `rst` aborts any operation. On the next cycle the block is in state 0 with the engine stopped.
- R12: Each command taken while selected yields exactly one of `cmd_accept` or `cmd_reject`, as a one-cycle pulse on the following cycle. A rejected command leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts operations |
| ce_n | input | 1 | Chip select, active low; high means standby |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 4 | Command code (see R2) |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_block | input | BLK_W | Target block within the bank |
| eng_done | input | 1 | Engine finished the running operation |
| cmd_accept | output | 1 | Previous-cycle command accepted |
| cmd_reject | output | 1 | Previous-cycle command rejected |
| read_status | output | 1 | 1: reads return status; 0: array or identifier data |
| eng_run | output | 1 | Engine may run |
| eng_pause | output | 1 | Engine holds a suspended operation |
| op_state | output | 3 | Current operation state (see R1) |

## Verification
The assertions assume that `eng_done` is pulsed only by an engine that was told to run. A completion seen in a suspended state must therefore be a stray pulse that the block ignores. They also assume that commands offered during reset are lost rather than answered. The directed stimulus keeps to these assumptions: it never holds `cmd_valid` while `rst` is high, and it raises `eng_done` in a paused state only to show that the pulse is dropped. Collisions between a command and a completion are driven on purpose, in a running state only.

// File: rtl/susp_pkg.sv
package susp_pkg;

  typedef enum logic [3:0] {
    CMD_READ      = 4'd0,
    CMD_RD_STATUS = 4'd1,
    CMD_RD_SIG    = 4'd2,
    CMD_QUERY     = 4'd3,
    CMD_PROGRAM   = 4'd4,
    CMD_ERASE     = 4'd5,
    CMD_SUSPEND   = 4'd6,
    CMD_RESUME    = 4'd7,
    CMD_LOCK      = 4'd8,
    CMD_LOCKDOWN  = 4'd9,
    CMD_PROTECT   = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE            = 3'd0,
    ST_ERASING         = 3'd1,
    ST_ERASE_SUSP      = 3'd2,
    ST_PROG_IN_ES      = 3'd3,
    ST_PROG_SUSP_IN_ES = 3'd4,
    ST_PROGRAMMING     = 3'd5,
    ST_PROG_SUSP       = 3'd6
  } op_state_e;

  typedef enum logic [1:0] {
    RM_KEEP   = 2'd0,
    RM_ARRAY  = 2'd1,
    RM_STATUS = 2'd2
  } rmode_e;

  typedef struct packed {
    logic      legal;
    op_state_e nxt;
    rmode_e    rmode;
    logic      ld_erase;
    logic      ld_prog;
  } verdict_t;

  function automatic logic st_running(op_state_e s);
    return (s == ST_ERASING) || (s == ST_PROGRAMMING) || (s == ST_PROG_IN_ES);
  endfunction

  function automatic logic st_paused(op_state_e s);
    return (s == ST_ERASE_SUSP) || (s == ST_PROG_SUSP) || (s == ST_PROG_SUSP_IN_ES);
  endfunction

endpackage

// File: rtl/susp_owner.sv
module susp_owner #(
  parameter int KEY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [KEY_W-1:0] key_in,
  output logic [KEY_W-1:0] key_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
    end else if (load) begin
      key_q <= key_in;
    end
  end

endmodule

// File: rtl/susp_decide.sv
module susp_decide
  import susp_pkg::*;
(
  input  op_state_e  st,
  input  logic [3:0] cmd_code,
  input  logic       hit_ebank,
  input  logic       hit_eblock,
  input  logic       hit_pbank,
  output verdict_t   v
);

  cmd_e c;
  logic ident_rd;

  assign c        = cmd_e'(cmd_code);
  assign ident_rd = (c == CMD_READ) || (c == CMD_RD_SIG) || (c == CMD_QUERY);

  always_comb begin
    v       = '0;
    v.nxt   = st;
    v.rmode = RM_KEEP;
    case (st)
      ST_IDLE: begin
        case (c)
          CMD_READ, CMD_RD_SIG, CMD_QUERY: begin
            v.legal = 1'b1;
            v.rmode = RM_ARRAY;
          end
          CMD_RD_STATUS: begin
            v.legal = 1'b1;
            v.rmode = RM_STATUS;
          end
          CMD_PROGRAM: begin
            v.legal   = 1'b1;
            v.nxt     = ST_PROGRAMMING;
            v.rmode   = RM_STATUS;
            v.ld_prog = 1'b1;
          end
          CMD_ERASE: begin
            v.legal    = 1'b1;
            v.nxt      = ST_ERASING;
            v.rmode    = RM_STATUS;
            v.ld_erase = 1'b1;
          end
          CMD_LOCK, CMD_LOCKDOWN, CMD_PROTECT: v.legal = 1'b1;
          default: v.legal = 1'b0;
        endcase
      end
      ST_ERASING: begin
        if (c == CMD_RD_STATUS) begin
          v.legal = 1'b1;
          v.rmode = RM_STATUS;
        end else if (c == CMD_SUSPEND && hit_ebank) begin
          v.legal = 1'b1;
          v.nxt   = ST_ERASE_SUSP;
          v.rmode = RM_STATUS;
        end else if (c == CMD_READ && !hit_ebank) begin
          v.legal = 1'b1;
        end
      end
      ST_PROGRAMMING, ST_PROG_IN_ES: begin
        if (c == CMD_RD_STATUS) begin
          v.legal = 1'b1;
          v.rmode = RM_STATUS;
        end else if (c == CMD_SUSPEND && hit_pbank) begin
          v.legal = 1'b1;
          v.nxt   = (st == ST_PROGRAMMING) ? ST_PROG_SUSP : ST_PROG_SUSP_IN_ES;
          v.rmode = RM_STATUS;
        end else if (c == CMD_READ && !hit_pbank) begin
          v.legal = 1'b1;
        end
      end
      ST_ERASE_SUSP: begin
        if (ident_rd) begin
          v.legal = 1'b1;
          v.rmode = RM_ARRAY;
        end else if (c == CMD_RD_STATUS) begin
          v.legal = 1'b1;
          v.rmode = RM_STATUS;
        end else if (c == CMD_RESUME && hit_ebank) begin
          v.legal = 1'b1;
          v.nxt   = ST_ERASING;
          v.rmode = RM_STATUS;
        end else if (c == CMD_PROGRAM && !hit_eblock) begin
          v.legal   = 1'b1;
          v.nxt     = ST_PROG_IN_ES;
          v.rmode   = RM_STATUS;
          v.ld_prog = 1'b1;
        end else if (c == CMD_LOCK || c == CMD_LOCKDOWN || c == CMD_PROTECT) begin
          v.legal = 1'b1;
        end
      end
      ST_PROG_SUSP, ST_PROG_SUSP_IN_ES: begin
        if (ident_rd) begin
          v.legal = 1'b1;
          v.rmode = RM_ARRAY;
        end else if (c == CMD_RD_STATUS) begin
          v.legal = 1'b1;
          v.rmode = RM_STATUS;
        end else if (c == CMD_RESUME && hit_pbank) begin
          v.legal = 1'b1;
          v.nxt   = (st == ST_PROG_SUSP) ? ST_PROGRAMMING : ST_PROG_IN_ES;
          v.rmode = RM_STATUS;
        end
      end
      default: v.nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/susp_ctrl.sv
module susp_ctrl
  import susp_pkg::*;
#(
  parameter  int BANKS  = 2,
  parameter  int BLOCKS = 64,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [BLK_W-1:0]  cmd_block,
  input  logic              eng_done,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              read_status,
  output logic              eng_run,
  output logic              eng_pause,
  output logic [2:0]        op_state
);

  localparam int EKEY_W = BANK_W + BLK_W;

  op_state_e          state_q, state_n;
  verdict_t           v;
  logic               take_cmd, take_done;
  logic               acc_n, rej_n, rs_n;
  logic               ld_e, ld_p;
  logic [EKEY_W-1:0]  e_key;
  logic [BANK_W-1:0]  p_key;
  logic               hit_eb, hit_eblk, hit_pb;

  susp_owner #(.KEY_W(EKEY_W)) u_erase_owner (
    .clk    (clk),
    .rst    (rst),
    .load   (ld_e),
    .key_in ({cmd_bank, cmd_block}),
    .key_q  (e_key)
  );

  susp_owner #(.KEY_W(BANK_W)) u_prog_owner (
    .clk    (clk),
    .rst    (rst),
    .load   (ld_p),
    .key_in (cmd_bank),
    .key_q  (p_key)
  );

  assign hit_eb   = (cmd_bank == e_key[EKEY_W-1 -: BANK_W]);
  assign hit_eblk = (e_key == {cmd_bank, cmd_block});
  assign hit_pb   = (cmd_bank == p_key);

  susp_decide u_decide (
    .st         (state_q),
    .cmd_code   (cmd_code),
    .hit_ebank  (hit_eb),
    .hit_eblock (hit_eblk),
    .hit_pbank  (hit_pb),
    .v          (v)
  );

  assign take_cmd  = cmd_valid && !ce_n;
  assign take_done = eng_done && st_running(state_q);

  always_comb begin
    state_n = state_q;
    acc_n   = 1'b0;
    rej_n   = 1'b0;
    rs_n    = read_status;
    ld_e    = 1'b0;
    ld_p    = 1'b0;
    if (take_done) begin
      state_n = (state_q == ST_PROG_IN_ES) ? ST_ERASE_SUSP : ST_IDLE;
      rej_n   = take_cmd;
    end else if (take_cmd) begin
      if (v.legal) begin
        acc_n   = 1'b1;
        state_n = v.nxt;
        ld_e    = v.ld_erase;
        ld_p    = v.ld_prog;
        if (v.rmode == RM_ARRAY)  rs_n = 1'b0;
        if (v.rmode == RM_STATUS) rs_n = 1'b1;
      end else begin
        rej_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cmd_accept  <= 1'b0;
      cmd_reject  <= 1'b0;
      read_status <= 1'b0;
      eng_run     <= 1'b0;
      eng_pause   <= 1'b0;
    end else begin
      state_q     <= state_n;
      cmd_accept  <= acc_n;
      cmd_reject  <= rej_n;
      read_status <= rs_n;
      eng_run     <= st_running(state_n);
      eng_pause   <= st_paused(state_n);
    end
  end

  assign op_state = state_q;

endmodule

// File: rtl/susp_ctrl_chk.sv
module susp_ctrl_chk
  import susp_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ce_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic       eng_done,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic       read_status,
  input logic       eng_run,
  input logic       eng_pause,
  input logic [2:0] op_state
);

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    !(cmd_accept && cmd_reject)); // R12

  AST_VERDICT_PER_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept || cmd_reject) == $past(cmd_valid && !ce_n && !rst)); // R12

  AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    (cmd_reject && !$past(eng_done)) |-> $stable(op_state)); // R12

  AST_RUN_PAUSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(eng_run && eng_pause)); // R3

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ce_n && !eng_done) |=> ($stable(op_state) && $stable(eng_pause))); // R10

  AST_RESET_ABORT: assert property (@(posedge clk)
    rst |=> (op_state == ST_IDLE && !eng_run && !eng_pause)); // R11

  AST_NO_EARLY_ERASE_RESUME: assert property (@(posedge clk) disable iff (rst)
    (op_state == ST_PROG_IN_ES) |=> (op_state != ST_ERASING)); // R9

  AST_STATUS_AFTER_RESUME: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && $past(cmd_code == CMD_RESUME)) |-> read_status); // R8

endmodule

bind susp_ctrl susp_ctrl_chk u_chk (.*);

// File: tb/susp_ctrl_tb.sv
`timescale 1ns/1ps
module susp_ctrl_tb;

  localparam int BANK_W = 1;
  localparam int BLK_W  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [3:0]        cmd_code = '0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [BLK_W-1:0]  cmd_block = '0;
  logic              eng_done = 1'b0;
  logic              cmd_accept, cmd_reject, read_status, eng_run, eng_pause;
  logic [2:0]        op_state;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [3:0] RD = 0, RS = 1, SIG = 2, QRY = 3, PRG = 4, ERS = 5,
                         SUS = 6, RES = 7, LCK = 8, LKD = 9, PRT = 10;

  always #2.5 clk = ~clk;

  susp_ctrl u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_block(cmd_block),
    .eng_done(eng_done), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .read_status(read_status), .eng_run(eng_run), .eng_pause(eng_pause),
    .op_state(op_state)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // exp_rs < 0 means read_status is not checked
  task automatic send(input logic [3:0] code, input int bank, input int blk,
                      input bit exp_acc, input int exp_st, input int exp_rs,
                      input string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_bank  = bank[BANK_W-1:0];
    cmd_block = blk[BLK_W-1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!ce_n) begin
      chk(cmd_accept, exp_acc, {tag, " accept"});
      chk(cmd_reject, !exp_acc, {tag, " reject"});
    end else begin
      chk(cmd_accept || cmd_reject, 0, {tag, " no verdict in standby"});
    end
    chk(op_state, exp_st, {tag, " state"});
    if (exp_rs >= 0) chk(read_status, exp_rs, {tag, " read_status"});
  endtask

  task automatic pulse_done(input int exp_st, input string tag);
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    chk(op_state, exp_st, tag);
  endtask

  task automatic t_reset();
    do_reset();
    chk(op_state, 0, "R1 state");
    chk({eng_run, eng_pause, read_status, cmd_accept, cmd_reject}, 0, "R1 outputs");
  endtask

  task automatic t_plain_program();
    do_reset();
    send(SUS, 0, 0, 0, 0, 0, "R2 suspend in idle");
    send(RES, 0, 0, 0, 0, 0, "R2 resume in idle");
    send(PRG, 0, 5, 1, 5, 1, "R2 program start");
    chk(eng_run, 1, "R2 run");
    send(RD, 0, 0, 0, 5, 1, "R4 read own bank");
    send(RD, 1, 0, 1, 5, 1, "R4 read other bank");
    send(LCK, 0, 0, 0, 5, 1, "R4 lock while running");
    send(SUS, 1, 0, 0, 5, 1, "R3 suspend wrong bank");
    send(SUS, 0, 0, 1, 6, 1, "R3 suspend program");
    chk({eng_run, eng_pause}, 1, "R3 pause");
    send(RD, 0, 9, 1, 6, 0, "R6 array read");
    send(QRY, 0, 0, 1, 6, 0, "R6 query");
    send(RS, 0, 0, 1, 6, 1, "R6 status read");
    send(LCK, 1, 0, 0, 6, 1, "R7 lock in program suspend");
    send(PRG, 1, 0, 0, 6, 1, "R7 program in program suspend");
    send(RES, 1, 0, 0, 6, 1, "R8 resume wrong bank");
    send(RD, 0, 0, 1, 6, 0, "R6 array read again");
    send(RES, 0, 0, 1, 5, 1, "R8 resume program");
    pulse_done(0, "R5 program done");
    chk(eng_run, 0, "R5 engine stops");
  endtask

  task automatic t_nested();
    do_reset();
    send(ERS, 0, 3, 1, 1, 1, "R2 erase start");
    send(SUS, 0, 0, 1, 2, 1, "R3 suspend erase");
    send(PRG, 0, 3, 0, 2, 1, "R7 program erased block");
    send(SIG, 0, 0, 1, 2, 0, "R6 signature read");
    send(PRG, 1, 0, 1, 3, 1, "R7 program in erase suspend");
    chk({eng_run, eng_pause}, 2, "R7 engine runs program");
    send(RES, 0, 0, 0, 3, 1, "R9 erase resume blocked");
    send(SUS, 1, 0, 1, 4, 1, "R3 nested suspend");
    send(RD, 0, 7, 1, 4, 0, "R6 array read while nested");
    send(RES, 0, 0, 0, 4, 0, "R9 erase resume blocked nested");
    send(RES, 1, 0, 1, 3, 1, "R8 resume nested program");
    pulse_done(2, "R5 nested program done");
    chk(eng_pause, 1, "R5 back to erase pause");
    send(LKD, 0, 3, 1, 2, 1, "R7 lock-down in erase suspend");
    send(PRT, 0, 0, 1, 2, 1, "R7 protection program");
    send(RES, 0, 0, 1, 1, 1, "R8 resume erase");
    pulse_done(0, "R5 erase done");
  endtask

  task automatic t_done_and_collide();
    do_reset();
    send(PRG, 1, 2, 1, 5, 1, "R2 program bank1");
    send(SUS, 1, 0, 1, 6, 1, "R3 suspend bank1");
    pulse_done(6, "R5 done ignored while paused");
    send(RES, 1, 0, 1, 5, 1, "R8 resume bank1");
    @(negedge clk);
    eng_done  = 1'b1;
    cmd_valid = 1'b1;
    cmd_code  = RS;
    @(negedge clk);
    eng_done  = 1'b0;
    cmd_valid = 1'b0;
    chk(cmd_reject, 1, "R5 collision reject");
    chk(op_state, 0, "R5 collision completes");
  endtask

  task automatic t_standby();
    do_reset();
    send(ERS, 1, 1, 1, 1, 1, "R2 erase bank1");
    send(SUS, 1, 0, 1, 2, 1, "R3 suspend bank1 erase");
    ce_n = 1'b1;
    send(RES, 1, 0, 0, 2, 1, "R10 resume in standby");
    chk(eng_pause, 1, "R10 pause kept");
    ce_n = 1'b0;
    send(RES, 1, 0, 1, 1, 1, "R10 resume after standby");
  endtask

  task automatic t_abort();
    do_reset();
    send(ERS, 0, 1, 1, 1, 1, "R11 erase");
    send(SUS, 0, 0, 1, 2, 1, "R11 suspend");
    send(PRG, 1, 4, 1, 3, 1, "R11 nested program");
    send(SUS, 1, 0, 1, 4, 1, "R11 nested suspend");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(op_state, 0, "R11 abort state");
    chk({eng_run, eng_pause}, 0, "R11 abort engine");
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_plain_program();
    t_nested();
    t_done_and_collide();
    t_standby();
    t_abort();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule